// File: doc/BRIEF.md
# Dual-Clock First-Word-Fall-Through FIFO with Retransmit

A one-way buffer of 512 words of 36 bits. Port A writes on its own clock and port B reads on another; the two clocks may be unrelated or may be the same net. The read side presents the oldest stored word on `b_data_o` as soon as `b_ready_o` is high, with no read needed to fetch it. A read consumes that word and the next one appears.

Port A has an input-ready flag and a programmable almost-full flag. Port B has an output-ready flag and a programmable almost-empty flag. Both offsets reset to 8. They can be reloaded in two ways: by a port A write while `a_ofs_i` is high, or one bit at a time through a serial pair in the port A domain.

A retransmit mode on port B saves the read position on entry. A rewind pulse then returns reading to that saved point. While the mode is held, the saved words count as occupied, so writes cannot overwrite them. Pointers cross between the clock domains in gray code.

Top module: `dc_fwft_fifo`

## Requirements
- R1: While `rst_ni` is low, `a_ready_o` and `b_ready_o` are low and both pointers clear. After release, `a_ready_o` rises, `b_aempty_o` is high, `a_afull_o` is low, and both offsets are 8.
- R2: When `b_ready_o` is high, `b_data_o` already holds the oldest unread word, with no read issued.
- R3: Words leave port B in the order they were written. A read is `b_cs_i & b_rd_i & b_en_i` on a rising `b_clk_i` edge, and it is accepted only while `b_ready_o` is high.
- R4: A write is `a_cs_i & a_wr_i & a_en_i` with `a_ofs_i` low. Once 512 words are held, `a_ready_o` goes low, and a write while `a_ready_o` is low is not stored.
- R5: A read while `b_ready_o` is low does not move the read position.
- R6: `b_aempty_o` is high when the stored count is at or below the almost-empty offset.
- R7: `a_afull_o` is high when the free space is at or below the almost-full offset.
- R8: A port A write with `a_ofs_i` high loads the almost-empty offset from data bits [8:0] and the almost-full offset from bits [24:16]. It stores no word.
- R9: Each `a_clk_i` edge with `ser_en_i` high shifts the 18-bit chain {almost-full[8:0], almost-empty[8:0]} up by one place. `ser_d_i` enters bit 0 and almost-empty bit 8 moves into almost-full bit 0.
- R10: On the first cycle `rtm_i` is seen high, the read position is saved. A `rew_i` pulse while the mode is active restores that position, and the saved word reappears on `b_data_o`.
- R11: While retransmit mode is active, words from the saved position onward count as occupied for `a_ready_o` and `a_afull_o`. Leaving the mode frees the words read since.
- R12: Each pointer value passed between clock domains changes by at most one bit per source clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk_i | input | 1 | Port A clock |
| b_clk_i | input | 1 | Port B clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_cs_i | input | 1 | Port A select |
| a_wr_i | input | 1 | Port A write direction |
| a_en_i | input | 1 | Port A enable |
| a_ofs_i | input | 1 | Routes a port A write into the offset registers |
| a_data_i | input | 36 | Port A write data |
| a_ready_o | output | 1 | Input ready (space available) |
| a_afull_o | output | 1 | Almost-full flag |
| ser_en_i | input | 1 | Serial offset shift enable (port A clock) |
| ser_d_i | input | 1 | Serial offset data bit |
| b_cs_i | input | 1 | Port B select |
| b_rd_i | input | 1 | Port B read direction |
| b_en_i | input | 1 | Port B enable |
| b_data_o | output | 36 | Oldest unread word |
| b_ready_o | output | 1 | Output ready (word valid) |
| b_aempty_o | output | 1 | Almost-empty flag |
| rtm_i | input | 1 | Retransmit mode |
| rew_i | input | 1 | Rewind to the saved read position |

## Verification
A read pointer that slips shows up within one read as a repeated or skipped word on `b_data_o`. A write pointer that advances while blocked shows up as a stray word after a full drain. A lost or stale retransmit mark shows up two ways: a wrong word right after the rewind edge, or `a_ready_o` rising too early while the mode holds a full buffer. Flag or offset errors appear on the almost-flags within a few cycles of settling. Each test therefore checks the flags at exact fill levels, one word on either side of the threshold.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
  typedef enum logic [1:0] {
    A_IDLE,
    A_PUSH,
    A_LOAD
  } a_op_e;

  localparam int unsigned OFS_RESET = 8;
  localparam int unsigned AF_LSB    = 16;
endpackage

// File: rtl/ff_mem.sv
module ff_mem #(
  parameter int unsigned DW = 36,
  parameter int unsigned AW = 9
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/ff_gsync.sv
module ff_gsync #(
  parameter int unsigned W = 10
) (
  input  logic         src_clk_i,
  input  logic         dst_clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] bin_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] gray_q, s1_q, s2_q;

  function automatic logic [W-1:0] g2b(input logic [W-1:0] g);
    logic [W-1:0] b;
    b[W-1] = g[W-1];
    for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  always_ff @(posedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni) gray_q <= '0;
    else         gray_q <= bin_i ^ (bin_i >> 1);
  end

  always_ff @(posedge dst_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_q;
      s2_q <= s1_q;
    end
  end

  assign bin_o = g2b(s2_q);

  AST_GRAY_ONE_STEP: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    $countones(gray_q ^ $past(gray_q)) <= 1); // R12
endmodule

// File: rtl/ff_wr_side.sv
module ff_wr_side
  import fifo_pkg::*;
#(
  parameter int unsigned DW = 36,
  parameter int unsigned AW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          wr_i,
  input  logic          en_i,
  input  logic          ofs_i,
  input  logic [DW-1:0] data_i,
  input  logic          ser_en_i,
  input  logic          ser_d_i,
  input  logic [AW:0]   rel_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0]   wptr_o,
  output logic          ready_o,
  output logic          afull_o,
  output logic [AW-1:0] ae_ofs_o
);
  localparam int unsigned PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(1) << AW;

  a_op_e         op;
  logic          req;
  logic [PW-1:0] wptr_q, wptr_n, used_n, free_n;
  logic [AW-1:0] af_q, ae_q;
  logic          ir_q, af_flag_q;

  assign req = cs_i & wr_i & en_i;

  always_comb begin
    op = A_IDLE;
    if (req && ofs_i)      op = A_LOAD;
    else if (req && ir_q)  op = A_PUSH;
  end

  assign wptr_n = wptr_q + PW'(op == A_PUSH);
  assign used_n = wptr_n - rel_i;
  assign free_n = DEPTH_P - used_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q    <= '0;
      ir_q      <= 1'b0;
      af_flag_q <= 1'b0;
      af_q      <= AW'(OFS_RESET);
      ae_q      <= AW'(OFS_RESET);
    end else begin
      wptr_q    <= wptr_n;
      ir_q      <= ~used_n[AW];
      af_flag_q <= free_n <= {1'b0, af_q};
      if (op == A_LOAD) begin
        ae_q <= data_i[AW-1:0];
        af_q <= data_i[AF_LSB +: AW];
      end else if (ser_en_i) begin
        {af_q, ae_q} <= {af_q[AW-2:0], ae_q, ser_d_i};
      end
    end
  end

  assign we_o     = (op == A_PUSH);
  assign waddr_o  = wptr_q[AW-1:0];
  assign wptr_o   = wptr_q;
  assign ready_o  = ir_q;
  assign afull_o  = af_flag_q;
  assign ae_ofs_o = ae_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wptr_q - rel_i) <= DEPTH_P); // R4
  AST_BLOCKED_WRITE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req && !ready_o) |=> $stable(wptr_o)); // R4
endmodule

// File: rtl/ff_rd_side.sv
module ff_rd_side #(
  parameter int unsigned AW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          rd_i,
  input  logic          en_i,
  input  logic          rtm_i,
  input  logic          rew_i,
  input  logic [AW:0]   wsync_i,
  input  logic [AW-1:0] ae_ofs_i,
  output logic [AW-1:0] raddr_o,
  output logic          ready_o,
  output logic          aempty_o,
  output logic [AW:0]   rel_o
);
  localparam int unsigned PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(1) << AW;

  logic [PW-1:0] rptr_q, rptr_n, mark_q, rel_q, target, cnt_n;
  logic [AW-1:0] ofs_s1_q, ofs_s2_q;
  logic          rtm_q, or_q, ae_q, rd_acc;

  assign rd_acc = cs_i & rd_i & en_i & or_q;
  assign rptr_n = (rtm_q && rew_i) ? mark_q : rptr_q + PW'(rd_acc);
  assign cnt_n  = wsync_i - rptr_n;
  assign target = rtm_q ? mark_q : rptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q   <= '0;
      mark_q   <= '0;
      rel_q    <= '0;
      rtm_q    <= 1'b0;
      or_q     <= 1'b0;
      ae_q     <= 1'b1;
      ofs_s1_q <= AW'(fifo_pkg::OFS_RESET);
      ofs_s2_q <= AW'(fifo_pkg::OFS_RESET);
    end else begin
      // offset is quasi-static: reload only while the read side is idle
      ofs_s1_q <= ae_ofs_i;
      ofs_s2_q <= ofs_s1_q;
      rtm_q    <= rtm_i;
      if (rtm_i && !rtm_q) mark_q <= rptr_q;
      rptr_q   <= rptr_n;
      or_q     <= cnt_n != '0;
      ae_q     <= cnt_n <= {1'b0, ofs_s2_q};
      // released pointer walks one step per cycle to keep the gray crossing clean
      if (rel_q != target) rel_q <= rel_q + PW'(1);
    end
  end

  assign raddr_o  = rptr_q[AW-1:0];
  assign ready_o  = or_q;
  assign aempty_o = ae_q;
  assign rel_o    = rel_q;

  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wsync_i - rptr_q) <= DEPTH_P); // R5
  AST_READY_HAS_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (wsync_i != rptr_q)); // R2
  AST_RELEASE_BEHIND_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rptr_q - rel_q) <= DEPTH_P); // R11
  AST_MARK_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rtm_q && $past(rtm_q)) |-> $stable(mark_q)); // R10
endmodule

// File: rtl/dc_fwft_fifo.sv
module dc_fwft_fifo #(
  parameter int unsigned DW = 36,
  parameter int unsigned AW = 9
) (
  input  logic          a_clk_i,
  input  logic          b_clk_i,
  input  logic          rst_ni,
  input  logic          a_cs_i,
  input  logic          a_wr_i,
  input  logic          a_en_i,
  input  logic          a_ofs_i,
  input  logic [DW-1:0] a_data_i,
  output logic          a_ready_o,
  output logic          a_afull_o,
  input  logic          ser_en_i,
  input  logic          ser_d_i,
  input  logic          b_cs_i,
  input  logic          b_rd_i,
  input  logic          b_en_i,
  output logic [DW-1:0] b_data_o,
  output logic          b_ready_o,
  output logic          b_aempty_o,
  input  logic          rtm_i,
  input  logic          rew_i
);
  localparam int unsigned PW = AW + 1;

  logic          we;
  logic [AW-1:0] waddr, raddr, ae_ofs;
  logic [PW-1:0] wptr, wsync, rel, rel_sync;

  ff_wr_side #(.DW(DW), .AW(AW)) u_wr (
    .clk_i(a_clk_i), .rst_ni(rst_ni),
    .cs_i(a_cs_i), .wr_i(a_wr_i), .en_i(a_en_i), .ofs_i(a_ofs_i), .data_i(a_data_i),
    .ser_en_i(ser_en_i), .ser_d_i(ser_d_i), .rel_i(rel_sync),
    .we_o(we), .waddr_o(waddr), .wptr_o(wptr),
    .ready_o(a_ready_o), .afull_o(a_afull_o), .ae_ofs_o(ae_ofs)
  );

  ff_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk_i(a_clk_i), .we_i(we), .waddr_i(waddr), .wdata_i(a_data_i),
    .raddr_i(raddr), .rdata_o(b_data_o)
  );

  ff_gsync #(.W(PW)) u_w2r (
    .src_clk_i(a_clk_i), .dst_clk_i(b_clk_i), .rst_ni(rst_ni),
    .bin_i(wptr), .bin_o(wsync)
  );

  ff_gsync #(.W(PW)) u_r2w (
    .src_clk_i(b_clk_i), .dst_clk_i(a_clk_i), .rst_ni(rst_ni),
    .bin_i(rel), .bin_o(rel_sync)
  );

  ff_rd_side #(.AW(AW)) u_rd (
    .clk_i(b_clk_i), .rst_ni(rst_ni),
    .cs_i(b_cs_i), .rd_i(b_rd_i), .en_i(b_en_i),
    .rtm_i(rtm_i), .rew_i(rew_i), .wsync_i(wsync), .ae_ofs_i(ae_ofs),
    .raddr_o(raddr), .ready_o(b_ready_o), .aempty_o(b_aempty_o), .rel_o(rel)
  );
endmodule

// File: tb/sim_dc_fwft_fifo.sv
`timescale 1ns/1ps
module sim_dc_fwft_fifo;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        a_cs = 0, a_wr = 0, a_en = 0, a_ofs = 0, ser_en = 0, ser_d = 0;
  logic [35:0] a_d = '0;
  logic        b_cs = 0, b_rd = 0, b_en = 0, rtm = 0, rew = 0;
  logic        a_ready, a_afull, b_ready, b_aempty;
  logic [35:0] b_data;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  dc_fwft_fifo u0 (
    .a_clk_i(clk), .b_clk_i(clk), .rst_ni(rst_ni),
    .a_cs_i(a_cs), .a_wr_i(a_wr), .a_en_i(a_en), .a_ofs_i(a_ofs), .a_data_i(a_d),
    .a_ready_o(a_ready), .a_afull_o(a_afull), .ser_en_i(ser_en), .ser_d_i(ser_d),
    .b_cs_i(b_cs), .b_rd_i(b_rd), .b_en_i(b_en), .b_data_o(b_data),
    .b_ready_o(b_ready), .b_aempty_o(b_aempty), .rtm_i(rtm), .rew_i(rew)
  );

  function automatic logic [35:0] pat(int i);
    return 36'h9A0000000 + 36'(i);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic push(input logic [35:0] d);
    a_cs = 1; a_wr = 1; a_en = 1; a_d = d;
    @(negedge clk);
    a_cs = 0; a_wr = 0; a_en = 0;
  endtask

  task automatic pop_chk(input logic [35:0] exp, input string tag);
    chk(b_ready == 1'b1, {tag, " ready"}, 36'(b_ready), 36'd1);
    chk(b_data == exp, {tag, " data"}, b_data, exp);
    b_cs = 1; b_rd = 1; b_en = 1;
    @(negedge clk);
    b_cs = 0; b_rd = 0; b_en = 0;
  endtask

  task automatic do_reset();
    rst_ni = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    settle();
  endtask

  task automatic t_reset();
    rst_ni = 0;
    repeat (3) @(negedge clk);
    chk(a_ready == 1'b0, "R1 a_ready in reset", 36'(a_ready), 36'd0);
    chk(b_ready == 1'b0, "R1 b_ready in reset", 36'(b_ready), 36'd0);
    rst_ni = 1;
    settle();
    chk(a_ready == 1'b1, "R1 a_ready after reset", 36'(a_ready), 36'd1);
    chk(b_aempty == 1'b1, "R1 aempty after reset", 36'(b_aempty), 36'd1);
    chk(a_afull == 1'b0, "R1 afull after reset", 36'(a_afull), 36'd0);
  endtask

  task automatic t_fwft();
    do_reset();
    b_cs = 1; b_rd = 1; b_en = 1;   // read while empty
    @(negedge clk);
    b_cs = 0; b_rd = 0; b_en = 0;
    push(36'h123456789);
    settle();
    chk(b_ready == 1'b1, "R2 ready without read", 36'(b_ready), 36'd1);
    chk(b_data == 36'h123456789, "R5 R2 first word", b_data, 36'h123456789);
    pop_chk(36'h123456789, "R3");
    settle();
    chk(b_ready == 1'b0, "R5 empty after pop", 36'(b_ready), 36'd0);
    b_cs = 1; b_rd = 1; b_en = 1;
    repeat (2) @(negedge clk);
    b_cs = 0; b_rd = 0; b_en = 0;
    push(36'hABCDE0123);
    settle();
    chk(b_data == 36'hABCDE0123, "R5 next word after empty reads", b_data, 36'hABCDE0123);
  endtask

  task automatic t_ae_default();
    do_reset();
    for (int i = 0; i < 8; i++) push(pat(i));
    settle();
    chk(b_aempty == 1'b1, "R6 aempty at 8", 36'(b_aempty), 36'd1);
    push(pat(8));
    settle();
    chk(b_aempty == 1'b0, "R6 aempty at 9", 36'(b_aempty), 36'd0);
    for (int i = 0; i < 9; i++) pop_chk(pat(i), "R3 order");
  endtask

  task automatic t_full();
    do_reset();
    for (int i = 0; i < 503; i++) push(pat(i));
    settle();
    chk(a_afull == 1'b0, "R7 afull free 9", 36'(a_afull), 36'd0);
    push(pat(503));
    settle();
    chk(a_afull == 1'b1, "R7 afull free 8", 36'(a_afull), 36'd1);
    chk(a_ready == 1'b1, "R4 ready below full", 36'(a_ready), 36'd1);
    for (int i = 504; i < 512; i++) push(pat(i));
    settle();
    chk(a_ready == 1'b0, "R4 ready at full", 36'(a_ready), 36'd0);
    push(36'hBADBADBAD);
    settle();
    for (int i = 0; i < 512; i++) pop_chk(pat(i), "R3 R4 drain");
    settle();
    chk(b_ready == 1'b0, "R4 no stray word", 36'(b_ready), 36'd0);
  endtask

  task automatic t_par_load();
    do_reset();
    a_ofs = 1;
    push((36'd10 << 16) | 36'd3);
    a_ofs = 0;
    settle();
    chk(b_ready == 1'b0, "R8 load stores no word", 36'(b_ready), 36'd0);
    for (int i = 0; i < 3; i++) push(pat(i));
    settle();
    chk(b_aempty == 1'b1, "R8 aempty at 3", 36'(b_aempty), 36'd1);
    push(pat(3));
    settle();
    chk(b_aempty == 1'b0, "R8 aempty at 4", 36'(b_aempty), 36'd0);
    for (int i = 4; i < 501; i++) push(pat(i));
    settle();
    chk(a_afull == 1'b0, "R8 afull free 11", 36'(a_afull), 36'd0);
    push(pat(501));
    settle();
    chk(a_afull == 1'b1, "R8 afull free 10", 36'(a_afull), 36'd1);
  endtask

  task automatic t_ser_load();
    logic [17:0] v;
    do_reset();
    v = (18'd12 << 9) | 18'd5;
    for (int i = 17; i >= 0; i--) begin
      ser_en = 1; ser_d = v[i];
      @(negedge clk);
    end
    ser_en = 0; ser_d = 0;
    settle();
    for (int i = 0; i < 5; i++) push(pat(i));
    settle();
    chk(b_aempty == 1'b1, "R9 aempty at 5", 36'(b_aempty), 36'd1);
    push(pat(5));
    settle();
    chk(b_aempty == 1'b0, "R9 aempty at 6", 36'(b_aempty), 36'd0);
  endtask

  task automatic t_retransmit();
    do_reset();
    for (int i = 0; i < 512; i++) push(pat(i));
    settle();
    rtm = 1;
    @(negedge clk);
    for (int i = 0; i < 3; i++) pop_chk(pat(i), "R10 first pass");
    settle();
    chk(a_ready == 1'b0, "R11 marked words held", 36'(a_ready), 36'd0);
    chk(a_afull == 1'b1, "R11 afull held", 36'(a_afull), 36'd1);
    rew = 1;
    @(negedge clk);
    rew = 0;
    chk(b_data == pat(0), "R10 rewind word", b_data, pat(0));
    pop_chk(pat(0), "R10 replay");
    pop_chk(pat(1), "R10 replay");
    rtm = 0;
    settle();
    chk(a_ready == 1'b1, "R11 space freed on exit", 36'(a_ready), 36'd1);
    for (int i = 2; i < 512; i++) pop_chk(pat(i), "R3 after retransmit");
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_fwft();
    t_ae_default();
    t_full();
    t_par_load();
    t_ser_load();
    t_retransmit();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule